// File: doc/BRIEF.md
# Byte-Addressed Word Memory with Selectable Byte Order

This block is a small synchronous memory in which every address names one byte. A requester can store or load a byte, a half-word (two bytes), a word (four bytes) or a double-word (eight bytes), and the access size is picked per access. A mode input picks how the bytes of a multi-byte value are laid out across ascending addresses. In little-endian mode the low-order byte goes to the base address. In big-endian mode the high-order byte goes to the base address. One byte array serves both modes, so data stored in one order can be read back in the other.

A store presents the address, size, write data and the write strobe in one cycle, and memory is updated at that clock edge. A load presents the address, size and the read strobe, and the data appears on the read bus after the next clock edge. Loads narrower than the bus are zero-filled above the loaded bytes. Every multi-byte access must be naturally aligned. A misaligned access raises the error output in the cycle after its strobe. A misaligned store is dropped, and a misaligned load returns zero.

Top module: `endian_byte_mem`

## Requirements
- R1: Each address holds exactly one byte. A byte store to one address changes no other address.
- R2: In little-endian mode (`big_endian_i`=0), a word store of 0x46789654 at base A places bytes 0x54, 0x96, 0x78 and 0x46 at A, A+1, A+2 and A+3.
- R3: In big-endian mode (`big_endian_i`=1), the same word store places bytes 0x46, 0x78, 0x96 and 0x54 at A, A+1, A+2 and A+3.
- R4: `size_i` selects the access size: 0 for a byte, 1 for a half-word, 2 for a word and 3 for a double-word. An access with either strobe set is misaligned when its address is not a multiple of the access size in bytes. `misalign_o` is 1 in the cycle after a misaligned access and 0 after any other cycle.
- R5: A misaligned store leaves every byte of memory unchanged.
- R6: A misaligned load sets `rdata_o` to zero.
- R7: Load data appears on `rdata_o` one clock edge after the read strobe. `rdata_o` keeps its value in any cycle that follows a cycle without a read strobe.
- R8: A byte, half-word or word load returns the loaded value in the low bits of `rdata_o` (bits 7:0, 15:0 or 31:0), and all higher bits are zero.
- R9: A byte stored in one mode and loaded as a byte in the other mode returns the same value.
- R10: In either mode, an aligned load of any size returns the bytes last stored at its addresses, assembled in that mode's byte order.
- R11: If the read and write strobes are both set in the same cycle, the load returns the memory contents from before that store.
- R12: During reset, `rdata_o` and `misalign_o` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the output registers |
| big_endian_i | input | 1 | Byte order: 1 puts the high-order byte at the base address |
| addr_i | input | ADDR_W | Byte address of the access |
| size_i | input | 2 | Access size: 0 byte, 1 half-word, 2 word, 3 double-word |
| rd_en_i | input | 1 | Load strobe |
| wr_en_i | input | 1 | Store strobe |
| wdata_i | input | DATA_W | Store data, right-justified |
| rdata_o | output | DATA_W | Load data, zero-extended, valid one cycle after the load strobe |
| misalign_o | output | 1 | Alignment error for the access made in the previous cycle |

## Verification
The directed patterns store the word 0x46789654 in each mode and read it back one byte at a time. This tells a correct byte order apart from a reversed or rotated one. Bytes stored in one mode are then loaded in the other mode, which shows whether the byte path is independent of the mode. Other directed cases cover a misaligned store placed over a known double-word, a misaligned load, a load and a store in the same cycle, and an idle cycle after a load. These separate a dropped store from a partial one, and old read data from new. Random traffic with a fixed seed mixes all sizes, both modes and any address against a byte-level reference model. It catches wrong lane offsets, bad zero-fill and missed alignment checks at every size.

// File: rtl/emem_pkg.sv
// Package: shared types and helpers for the byte-addressed memory.
// Assumes the data bus is eight bytes wide, so the largest access is a double-word.
package emem_pkg;

    // Access size code carried on size_i
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/emem_align_chk.sv
// Module: emem_align_chk
// Flags an access whose address is not a multiple of its size in bytes.
// Assumes the access size in bytes is 2**size_i and is at most 2**OFF_W.
module emem_align_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned OFF_W  = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    output logic              misaligned_o
);

    logic [OFF_W:0]   nbytes;
    logic [OFF_W-1:0] low_mask;

    // Any set address bit below the size boundary means misaligned
    always_comb begin
        nbytes       = (OFF_W+1)'(1) << size_i;
        low_mask     = OFF_W'(nbytes - (OFF_W+1)'(1));
        misaligned_o = |(addr_i[OFF_W-1:0] & low_mask);
    end

endmodule

// File: rtl/emem_lane_map.sv
// Module: emem_lane_map
// For each byte lane of the data bus, gives whether the lane takes part in the
// access and which byte offset from the base address it maps to.
// Assumes lane 0 carries the least significant byte of the bus.
module emem_lane_map #(
    parameter int unsigned LANES = 8,
    parameter int unsigned OFF_W = 3
) (
    input  logic                        big_endian_i,
    input  logic [1:0]                  size_i,
    output logic [LANES-1:0]            lane_en_o,
    output logic [LANES-1:0][OFF_W-1:0] lane_off_o
);

    logic [OFF_W:0] nbytes;

    // Number of bytes touched by the access
    always_comb nbytes = (OFF_W+1)'(1) << size_i;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // Lane enable and offset: little-endian keeps lane order, big-endian mirrors it
        always_comb begin
            lane_en_o[k] = ((OFF_W+1)'(k) < nbytes);
            if (big_endian_i)
                lane_off_o[k] = OFF_W'(nbytes - (OFF_W+1)'(k) - (OFF_W+1)'(1));
            else
                lane_off_o[k] = OFF_W'(k);
        end
    end

endmodule

// File: rtl/emem_byte_store.sv
// Module: emem_byte_store
// Byte array with one write and one read per lane at base plus lane offset.
// Reads are combinational; disabled lanes read as zero. The array has no reset.
// Assumes enabled lanes address distinct bytes (guaranteed for aligned accesses).
module emem_byte_store #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANES  = 8,
    parameter int unsigned OFF_W  = 3
) (
    input  logic                        clk,
    input  logic                        we_i,
    input  logic [ADDR_W-1:0]           base_i,
    input  logic [LANES-1:0]            lane_en_i,
    input  logic [LANES-1:0][OFF_W-1:0] lane_off_i,
    input  logic [LANES*8-1:0]          wdata_i,
    output logic [LANES*8-1:0]          rlanes_o
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [7:0]                    mem [DEPTH];
    logic [LANES-1:0][ADDR_W-1:0]  lane_addr;

    for (genvar k = 0; k < LANES; k++) begin : g_port
        // Per-lane byte address and masked read
        always_comb begin
            lane_addr[k]        = base_i + ADDR_W'(lane_off_i[k]);
            rlanes_o[8*k +: 8]  = lane_en_i[k] ? mem[lane_addr[k]] : 8'h00;
        end
    end

    // Byte writes for every enabled lane
    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (we_i && lane_en_i[k])
                mem[lane_addr[k]] <= wdata_i[8*k +: 8];
        end
    end

endmodule

// File: rtl/endian_byte_mem.sv
// Module: endian_byte_mem (top)
// Byte-addressed memory with byte, half-word, word and double-word accesses in
// either byte order. Load data and the alignment error are registered one cycle
// after the strobe. Misaligned stores are dropped; misaligned loads return zero.
// Assumes DATA_W is 64, so size_i covers every access the bus can carry.
module endian_byte_mem #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_endian_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              misalign_o
);

    localparam int unsigned LANES = DATA_W / emem_pkg::BYTE_W;
    localparam int unsigned OFF_W = $clog2(LANES);

    logic                        misaligned;
    logic [LANES-1:0]            lane_en;
    logic [LANES-1:0][OFF_W-1:0] lane_off;
    logic [DATA_W-1:0]           rlanes;
    logic                        store_ok;

    emem_align_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_align (
        .addr_i       (addr_i),
        .size_i       (size_i),
        .misaligned_o (misaligned)
    );

    emem_lane_map #(.LANES(LANES), .OFF_W(OFF_W)) u_map (
        .big_endian_i (big_endian_i),
        .size_i       (size_i),
        .lane_en_o    (lane_en),
        .lane_off_o   (lane_off)
    );

    // Only aligned stores reach the array
    always_comb store_ok = wr_en_i && !misaligned;

    emem_byte_store #(.ADDR_W(ADDR_W), .LANES(LANES), .OFF_W(OFF_W)) u_store (
        .clk        (clk),
        .we_i       (store_ok),
        .base_i     (addr_i),
        .lane_en_i  (lane_en),
        .lane_off_i (lane_off),
        .wdata_i    (wdata_i),
        .rlanes_o   (rlanes)
    );

    // Output registers: load data capture and alignment error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o    <= '0;
            misalign_o <= 1'b0;
        end else begin
            misalign_o <= (rd_en_i || wr_en_i) && misaligned;
            if (rd_en_i)
                rdata_o <= misaligned ? '0 : rlanes;
        end
    end

endmodule

// File: rtl/emem_checker.sv
// Module: emem_checker
// Port-level properties of endian_byte_mem, attached with bind below.
// Recomputes alignment from the inputs independently of the design.
module emem_checker #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic [1:0]        size_i,
    input logic              rd_en_i,
    input logic              wr_en_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              misalign_o
);

    logic bad;

    // Independent alignment test per size code
    always_comb begin
        case (size_i)
            2'd1:    bad = addr_i[0];
            2'd2:    bad = |addr_i[1:0];
            2'd3:    bad = |addr_i[2:0];
            default: bad = 1'b0;
        endcase
    end

    assert_misalign_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en_i || wr_en_i) && bad) |=> misalign_o);

    assert_no_false_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !((rd_en_i || wr_en_i) && bad) |=> !misalign_o);

    assert_bad_load_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && bad) |=> (rdata_o == '0));

    assert_hold_rdata_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o));

    assert_zext_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && size_i == 2'd0) |=> (rdata_o[DATA_W-1:8] == '0));

    assert_zext_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && size_i == 2'd1) |=> (rdata_o[DATA_W-1:16] == '0));

    assert_zext_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && size_i == 2'd2) |=> (rdata_o[DATA_W-1:32] == '0));

endmodule

bind endian_byte_mem emem_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_emem_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr_i),
    .size_i     (size_i),
    .rd_en_i    (rd_en_i),
    .wr_en_i    (wr_en_i),
    .rdata_o    (rdata_o),
    .misalign_o (misalign_o)
);

// File: tb/tb_endian_byte_mem.sv
`timescale 1ns/1ps
module tb_endian_byte_mem;

    localparam int unsigned AW = 8;
    localparam int unsigned DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          big_endian_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [1:0]    size_i = '0;
    logic          rd_en_i = 1'b0;
    logic          wr_en_i = 1'b0;
    logic [DW-1:0] wdata_i = '0;
    logic [DW-1:0] rdata_o;
    logic          misalign_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [7:0]    ref_mem [256];
    logic [DW-1:0] last_rd = '0;

    always #2.5 clk = ~clk;

    endian_byte_mem #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .big_endian_i(big_endian_i), .addr_i(addr_i),
        .size_i(size_i), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .misalign_o(misalign_o)
    );

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_bad(input logic [1:0] sz, input logic [AW-1:0] a);
        int unsigned nb = 1 << sz;
        return (int'(a) % nb) != 0;
    endfunction

    function automatic logic [DW-1:0] model_load(input bit be, input logic [1:0] sz,
                                                  input logic [AW-1:0] a);
        logic [DW-1:0] v = '0;
        int unsigned nb = 1 << sz;
        for (int k = 0; k < int'(nb); k++) begin
            int unsigned off = be ? (nb - 1 - k) : k;
            v[8*k +: 8] = ref_mem[(int'(a) + off) % 256];
        end
        return v;
    endfunction

    task automatic model_store(input bit be, input logic [1:0] sz, input logic [AW-1:0] a,
                               input logic [DW-1:0] d);
        int unsigned nb = 1 << sz;
        for (int k = 0; k < int'(nb); k++) begin
            int unsigned off = be ? (nb - 1 - k) : k;
            ref_mem[(int'(a) + off) % 256] = d[8*k +: 8];
        end
    endtask

    // One access: drive at a falling edge, sample at the next falling edge, then idle
    task automatic access(input bit rd, input bit wr, input bit be, input logic [1:0] sz,
                          input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input string tag);
        logic [DW-1:0] exp_rd;
        bit exp_err;
        @(negedge clk);
        rd_en_i = rd; wr_en_i = wr; big_endian_i = be; size_i = sz;
        addr_i = a; wdata_i = wd;
        exp_err = (rd || wr) && is_bad(sz, a);
        if (rd) exp_rd = is_bad(sz, a) ? '0 : model_load(be, sz, a);
        else    exp_rd = last_rd;
        if (wr && !is_bad(sz, a)) model_store(be, sz, a, wd);
        @(negedge clk);
        check(rdata_o == exp_rd, tag, rdata_o, exp_rd);
        check(misalign_o == exp_err, {tag, " R4 flag"}, DW'(misalign_o), DW'(exp_err));
        last_rd = rdata_o;
        rd_en_i = 1'b0; wr_en_i = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            summary();
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R12: reset state
        check(rdata_o == '0, "R12 rdata", rdata_o, '0);
        check(misalign_o == 1'b0, "R12 flag", DW'(misalign_o), '0);
        @(negedge clk); rst_n = 1'b1;

        // Fill memory with known data
        for (int i = 0; i < 32; i++)
            access(0, 1, 0, 2'd3, AW'(i * 8), {$urandom, $urandom}, "fill");

        // R2: little-endian word layout
        access(0, 1, 0, 2'd2, 8'h10, 64'h46789654, "R2 store");
        access(1, 0, 0, 2'd0, 8'h10, '0, "R2 byte0");
        check(last_rd == 64'h54, "R2 A", last_rd, 64'h54);
        access(1, 0, 0, 2'd0, 8'h13, '0, "R2 byte3");
        check(last_rd == 64'h46, "R2 A+3", last_rd, 64'h46);

        // R3: big-endian word layout, seen with little-endian byte loads
        access(0, 1, 1, 2'd2, 8'h14, 64'h46789654, "R3 store");
        access(1, 0, 0, 2'd0, 8'h14, '0, "R3 byte0");
        check(last_rd == 64'h46, "R3 A", last_rd, 64'h46);
        access(1, 0, 0, 2'd0, 8'h17, '0, "R3 byte3");
        check(last_rd == 64'h54, "R3 A+3", last_rd, 64'h54);
        access(1, 0, 0, 2'd2, 8'h14, '0, "R3 LE word view");
        check(last_rd == 64'h54967846, "R3 swapped", last_rd, 64'h54967846);

        // R1: a byte store leaves its neighbours alone
        access(0, 1, 0, 2'd0, 8'h11, 64'hEE, "R1 store");
        access(1, 0, 0, 2'd2, 8'h10, '0, "R1 word");
        check(last_rd == 64'h4678EE54, "R1 neighbours", last_rd, 64'h4678EE54);

        // R9: byte round trip across modes
        access(0, 1, 0, 2'd0, 8'h40, 64'hA5, "R9 store LE");
        access(1, 0, 1, 2'd0, 8'h40, '0, "R9 load BE");
        check(last_rd == 64'hA5, "R9 LE->BE", last_rd, 64'hA5);
        access(0, 1, 1, 2'd0, 8'h41, 64'h3C, "R9 store BE");
        access(1, 0, 0, 2'd0, 8'h41, '0, "R9 load LE");
        check(last_rd == 64'h3C, "R9 BE->LE", last_rd, 64'h3C);

        // R5: misaligned store changes nothing
        access(0, 1, 0, 2'd3, 8'h20, 64'h0123456789ABCDEF, "R5 base");
        access(0, 1, 0, 2'd2, 8'h21, 64'hFFFFFFFF, "R5 bad store");
        access(1, 0, 0, 2'd3, 8'h20, '0, "R5 unchanged");
        check(last_rd == 64'h0123456789ABCDEF, "R5 data", last_rd, 64'h0123456789ABCDEF);

        // R6: misaligned load gives zero
        access(1, 0, 1, 2'd1, 8'h31, '0, "R6 bad load");
        check(last_rd == '0, "R6 zero", last_rd, '0);

        // R8: zero extension of a narrow load over all-ones data
        access(0, 1, 0, 2'd3, 8'h50, '1, "R8 ones");
        access(1, 0, 0, 2'd1, 8'h52, '0, "R8 half");
        check(last_rd == 64'hFFFF, "R8 zext", last_rd, 64'hFFFF);

        // R7: idle cycle keeps the last read data
        access(0, 0, 0, 2'd0, 8'h00, '0, "R7 hold");

        // R11: read and write in one cycle returns old data
        access(1, 1, 0, 2'd3, 8'h48, 64'hDEADBEEFCAFEF00D, "R11 same cycle");
        access(1, 0, 0, 2'd3, 8'h48, '0, "R11 after");
        check(last_rd == 64'hDEADBEEFCAFEF00D, "R11 new", last_rd, 64'hDEADBEEFCAFEF00D);

        // R10: random mixed traffic against the byte model
        for (int i = 0; i < 800; i++) begin
            logic [1:0] sz = 2'($urandom_range(0, 3));
            logic [AW-1:0] a = AW'($urandom);
            bit be = 1'($urandom);
            bit wr = ($urandom_range(0, 2) == 0);
            if (($urandom_range(0, 3) != 0)) a = a & ~AW'((1 << sz) - 1);
            access(!wr, wr, be, sz, a, {$urandom, $urandom}, "R10 random");
        end

        finished = 1;
        summary();
    end

endmodule